// File: doc/BRIEF.md
# Dual-Loop Synthesizer Divider and Phase Detector

This block is the digital heart of a two-loop frequency synthesizer, one loop for transmit and one for receive. A programmable reference divider counts crystal clocks and produces a base comparison rate. A small prescale network derives two slower rates from that base: one at a quarter of it, and one at a twenty-fifth of it, built from two divide-by-five stages. A two-bit region select picks which rate each loop compares against. Each loop has a 14-bit programmable channel divider. It counts clock-enable strobes that stand in for the VCO feedback edges.

Each loop ends in a three-state phase-frequency detector. The detector is modelled as a drive-high enable and a drive-low enable. When neither enable is asserted, the output is high impedance. A lock monitor watches the transmit detector and raises an active-low lock flag.

The divide ratios and the select arrive as parallel inputs. A ratio below the minimum is raised to the minimum. A new ratio is picked up only at the end of the current count. A 12-bit reference ratio of 2048 with a 10.24 MHz crystal gives a 5 kHz base rate. Typical channel ratios are 7215 for receive and 9966 for transmit.

Top module: `synth_core`

## Requirements
- R1: The reference divider emits one base tick every `max(ref_ratio,16)` clock cycles.
- R2: Each channel divider emits one tick every `max(ratio,16)` cycles in which its feedback enable is high. With an enable that is high on alternate cycles, the tick period is twice the ratio.
- R3: Rate B ticks once every 4 base ticks. Rate C ticks once every 25 base ticks. Both coincide with a base tick.
- R4: The select `rate_sel` maps the rates as follows. 2'b00 gives both loops the base rate. 2'b01 gives both loops rate B. 2'b10 gives transmit rate B and receive rate C. 2'b11 gives transmit rate C and receive rate B.
- R5: A ratio changed during a count does not alter that count. The new ratio applies from the period that follows the next terminal tick.
- R6: When the divided feedback arrives first or runs faster than the comparison rate, the loop asserts only its drive-low enable. When the feedback arrives later or runs slower, the loop asserts only its drive-high enable.
- R7: After reset, all drive enables are low and `lock_n` is high. When the feedback and comparison ticks fall in the same cycle, neither drive enable is ever asserted (high impedance).
- R8: `lock_n` goes low once 4 consecutive transmit comparisons each have a detector pulse narrower than 2 clocks. A 1-clock pulse still counts as clean.
- R9: A transmit detector pulse that reaches 2 clocks drives `lock_n` high on the next clock edge. Pulses of 2 clocks or more keep it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Synchronous active-low reset; also samples the ratios |
| ref_ratio | input | 12 | Reference divide ratio |
| rx_ratio | input | 14 | Receive channel divide ratio |
| tx_ratio | input | 14 | Transmit channel divide ratio |
| rate_sel | input | 2 | Region rate select |
| rx_fb_en | input | 1 | Receive feedback edge strobe |
| tx_fb_en | input | 1 | Transmit feedback edge strobe |
| tx_cmp_tick | output | 1 | Transmit comparison tick |
| rx_cmp_tick | output | 1 | Receive comparison tick |
| tx_div_tick | output | 1 | Transmit divided-feedback tick |
| rx_div_tick | output | 1 | Receive divided-feedback tick |
| tx_drv_hi | output | 1 | Transmit detector drive-high enable |
| tx_drv_lo | output | 1 | Transmit detector drive-low enable |
| rx_drv_hi | output | 1 | Receive detector drive-high enable |
| rx_drv_lo | output | 1 | Receive detector drive-low enable |
| lock_n | output | 1 | Transmit lock flag, low when locked |

## Verification
Two events can fall in the same cycle: the comparison tick and the divided-feedback tick. When they do, both detector flops set together, and the detector must clear them without driving either enable. The bench provokes this by enabling the feedback continuously, with a channel ratio equal to the comparison period, starting on the same edge as the reference. It then checks that no drive cycle appears and that lock is declared on the fourth comparison. Starting the feedback one cycle late and then two cycles late separates the pair. This shows that the one-clock pulse is tolerated and that the two-clock pulse is rejected.

// File: rtl/synth_pkg.sv
package synth_pkg;
  typedef enum logic [1:0] {RATE_BASE, RATE_QUARTER, RATE_SLOW} rate_e;

  function automatic rate_e tx_rate_of(input logic [1:0] sel);
    case (sel)
      2'b00:   return RATE_BASE;
      2'b01:   return RATE_QUARTER;
      2'b10:   return RATE_QUARTER;
      default: return RATE_SLOW;
    endcase
  endfunction

  function automatic rate_e rx_rate_of(input logic [1:0] sel);
    case (sel)
      2'b00:   return RATE_BASE;
      2'b01:   return RATE_QUARTER;
      2'b10:   return RATE_SLOW;
      default: return RATE_QUARTER;
    endcase
  endfunction
endpackage

// File: rtl/prog_divider.sv
module prog_divider #(
  parameter int W         = 14,
  parameter int MIN_RATIO = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] ratio_i,
  output logic         tick_o
);
  localparam logic [W-1:0] MINV = W'(MIN_RATIO);

  logic [W-1:0] cnt, cur;
  logic [W-1:0] ratio_c;

  assign ratio_c = (ratio_i < MINV) ? MINV : ratio_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= W'(1);
      cur    <= ratio_c;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (en) begin
        if (cnt >= cur) begin
          cnt    <= W'(1);
          cur    <= ratio_c;
          tick_o <= 1'b1;
        end else begin
          cnt <= cnt + W'(1);
        end
      end
    end
  end

  // R2: the minimum ratio keeps ticks apart
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  // R5: the working ratio moves only together with a terminal tick
  p_reload_at_terminal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur) |-> tick_o);
endmodule

// File: rtl/rate_prescaler.sv
module rate_prescaler #(
  parameter int DIV_Q     = 4,
  parameter int DIV_STAGE = 5,
  parameter int N_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic base_tick,
  output logic quarter_tick,
  output logic slow_tick
);
  localparam int QW = $clog2(DIV_Q);
  localparam int SW = $clog2(DIV_STAGE);

  logic [QW-1:0] q_cnt;
  logic [N_STAGES:0] carry;

  assign quarter_tick = base_tick && (q_cnt == QW'(DIV_Q - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)          q_cnt <= '0;
    else if (base_tick)  q_cnt <= quarter_tick ? '0 : q_cnt + QW'(1);
  end

  assign carry[0] = base_tick;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    logic [SW-1:0] s_cnt;
    assign carry[s+1] = carry[s] && (s_cnt == SW'(DIV_STAGE - 1));
    always_ff @(posedge clk) begin
      if (!rst_n)         s_cnt <= '0;
      else if (carry[s])  s_cnt <= carry[s+1] ? '0 : s_cnt + SW'(1);
    end
  end

  assign slow_tick = carry[N_STAGES];
endmodule

// File: rtl/phase_detector.sv
module phase_detector (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic vco_tick,
  output logic drv_hi,
  output logic drv_lo,
  output logic pair_o
);
  logic ref_q, vco_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      vco_q <= 1'b0;
    end else if (ref_q && vco_q) begin
      ref_q <= 1'b0;
      vco_q <= 1'b0;
    end else begin
      if (ref_tick) ref_q <= 1'b1;
      if (vco_tick) vco_q <= 1'b1;
    end
  end

  assign drv_hi = ref_q && !vco_q;
  assign drv_lo = vco_q && !ref_q;
  assign pair_o = ref_q && vco_q;

  // R6: a low drive starts only after a feedback tick
  p_lo_from_vco_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_lo) |-> $past(vco_tick));

  // R6: a high drive starts only after a comparison tick
  p_hi_from_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_hi) |-> $past(ref_tick));
endmodule

// File: rtl/lock_monitor.sv
module lock_monitor #(
  parameter int LOCK_CYCLES = 4,
  parameter int WIDE_LIMIT  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_on,
  input  logic pair_set,
  output logic lock_n
);
  localparam int GW = $clog2(LOCK_CYCLES + 1);
  localparam int WW = $clog2(WIDE_LIMIT + 1);

  logic [GW-1:0] good;
  logic [WW-1:0] wcnt;
  logic          locked;
  logic          wide;

  assign wide = pulse_on && (wcnt >= WW'(WIDE_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      good   <= '0;
      wcnt   <= '0;
      locked <= 1'b0;
    end else if (wide) begin
      good   <= '0;
      wcnt   <= WW'(WIDE_LIMIT);
      locked <= 1'b0;
    end else if (pair_set) begin
      wcnt <= '0;
      if (wcnt < WW'(WIDE_LIMIT)) begin
        if (good >= GW'(LOCK_CYCLES - 1)) begin
          good   <= GW'(LOCK_CYCLES);
          locked <= 1'b1;
        end else begin
          good <= good + GW'(1);
        end
      end
    end else if (pulse_on) begin
      wcnt <= wcnt + WW'(1);
    end
  end

  assign lock_n = !locked;

  // R9: a pulse reaching the width limit drops lock on the next edge
  p_wide_drops_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wide |=> lock_n);

  // R8: lock is declared only at the close of a comparison
  p_lock_after_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_n) |-> $past(pair_set));
endmodule

// File: rtl/synth_core.sv
module synth_core #(
  parameter int REF_W       = 12,
  parameter int CH_W        = 14,
  parameter int MIN_RATIO   = 16,
  parameter int DIV_Q       = 4,
  parameter int DIV_STAGE   = 5,
  parameter int LOCK_CYCLES = 4,
  parameter int WIDE_LIMIT  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [REF_W-1:0] ref_ratio,
  input  logic [CH_W-1:0] rx_ratio,
  input  logic [CH_W-1:0] tx_ratio,
  input  logic [1:0]      rate_sel,
  input  logic            rx_fb_en,
  input  logic            tx_fb_en,
  output logic            tx_cmp_tick,
  output logic            rx_cmp_tick,
  output logic            tx_div_tick,
  output logic            rx_div_tick,
  output logic            tx_drv_hi,
  output logic            tx_drv_lo,
  output logic            rx_drv_hi,
  output logic            rx_drv_lo,
  output logic            lock_n
);
  import synth_pkg::*;

  localparam int N_LOOP = 2;   // index 0 transmit, 1 receive

  logic base_tick, quarter_tick, slow_tick;
  logic [N_LOOP-1:0] fb_en, cmp_tick, div_tick, drv_hi, drv_lo, pair_set;
  logic [CH_W-1:0]   ch_ratio [N_LOOP];
  logic              rx_pair_unused;

  assign fb_en       = {rx_fb_en, tx_fb_en};
  assign ch_ratio[0] = tx_ratio;
  assign ch_ratio[1] = rx_ratio;

  prog_divider #(.W(REF_W), .MIN_RATIO(MIN_RATIO)) u_ref_div (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .ratio_i(ref_ratio), .tick_o(base_tick));

  rate_prescaler #(.DIV_Q(DIV_Q), .DIV_STAGE(DIV_STAGE), .N_STAGES(2)) u_pre (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
    .quarter_tick(quarter_tick), .slow_tick(slow_tick));

  for (genvar g = 0; g < N_LOOP; g++) begin : g_loop
    rate_e pick;
    always_comb begin
      pick = (g == 0) ? tx_rate_of(rate_sel) : rx_rate_of(rate_sel);
      case (pick)
        RATE_BASE:    cmp_tick[g] = base_tick;
        RATE_QUARTER: cmp_tick[g] = quarter_tick;
        default:      cmp_tick[g] = slow_tick;
      endcase
    end

    prog_divider #(.W(CH_W), .MIN_RATIO(MIN_RATIO)) u_ch_div (
      .clk(clk), .rst_n(rst_n), .en(fb_en[g]), .ratio_i(ch_ratio[g]),
      .tick_o(div_tick[g]));

    phase_detector u_pd (
      .clk(clk), .rst_n(rst_n), .ref_tick(cmp_tick[g]), .vco_tick(div_tick[g]),
      .drv_hi(drv_hi[g]), .drv_lo(drv_lo[g]), .pair_o(pair_set[g]));
  end

  assign rx_pair_unused = pair_set[1];

  lock_monitor #(.LOCK_CYCLES(LOCK_CYCLES), .WIDE_LIMIT(WIDE_LIMIT)) u_lock (
    .clk(clk), .rst_n(rst_n), .pulse_on(drv_hi[0] | drv_lo[0]),
    .pair_set(pair_set[0]), .lock_n(lock_n));

  assign tx_cmp_tick = cmp_tick[0];
  assign rx_cmp_tick = cmp_tick[1];
  assign tx_div_tick = div_tick[0];
  assign rx_div_tick = div_tick[1];
  assign tx_drv_hi   = drv_hi[0];
  assign tx_drv_lo   = drv_lo[0];
  assign rx_drv_hi   = drv_hi[1];
  assign rx_drv_lo   = drv_lo[1];
endmodule

// File: tb/synth_core_tb_top.sv
`timescale 1ns/1ps
module synth_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] ref_ratio = 12'd20;
  logic [13:0] rx_ratio = 14'd20, tx_ratio = 14'd20;
  logic [1:0]  rate_sel = 2'b00;
  logic rx_en_base = 1'b1, tx_en_base = 1'b1, rx_gate = 1'b0, tog = 1'b0;
  logic rx_fb_en, tx_fb_en;
  logic tx_cmp_tick, rx_cmp_tick, tx_div_tick, rx_div_tick;
  logic tx_drv_hi, tx_drv_lo, rx_drv_hi, rx_drv_lo, lock_n;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;
  always @(negedge clk) tog <= ~tog;
  assign rx_fb_en = rx_gate ? tog : rx_en_base;
  assign tx_fb_en = tx_en_base;

  synth_core dut_i (
    .clk(clk), .rst_n(rst_n), .ref_ratio(ref_ratio), .rx_ratio(rx_ratio),
    .tx_ratio(tx_ratio), .rate_sel(rate_sel), .rx_fb_en(rx_fb_en),
    .tx_fb_en(tx_fb_en), .tx_cmp_tick(tx_cmp_tick), .rx_cmp_tick(rx_cmp_tick),
    .tx_div_tick(tx_div_tick), .rx_div_tick(rx_div_tick),
    .tx_drv_hi(tx_drv_hi), .tx_drv_lo(tx_drv_lo), .rx_drv_hi(rx_drv_hi),
    .rx_drv_lo(rx_drv_lo), .lock_n(lock_n));

  function automatic int mult_of(input logic [1:0] sel, input bit is_tx);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return is_tx ? 4 : 25;
      default: return is_tx ? 25 : 4;
    endcase
  endfunction

  function automatic int floor16(input int r);
    return (r < 16) ? 16 : r;
  endfunction

  function automatic logic sig(input int which);
    case (which)
      0: return tx_cmp_tick;
      1: return rx_cmp_tick;
      2: return tx_div_tick;
      default: return rx_div_tick;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int tx_delay);
    rst_n = 1'b0;
    if (tx_delay > 0) tx_en_base = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    if (tx_delay > 0) begin
      repeat (tx_delay) @(negedge clk);
      tx_en_base = 1'b1;
    end
  endtask

  task automatic wait_tick(input int which);
    do @(negedge clk); while (!sig(which));
  endtask

  task automatic gap_of(input int which, output int gap);
    int n = 0;
    do begin @(negedge clk); n++; end while (!sig(which));
    gap = n;
  endtask

  task automatic drive_count(input int cycles, input bit tx, output int hi, output int lo);
    hi = 0; lo = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tx) begin hi += int'(tx_drv_hi); lo += int'(tx_drv_lo); end
      else    begin hi += int'(rx_drv_hi); lo += int'(rx_drv_lo); end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int g, r, hi, lo;
    void'($urandom(32'd1234));
    // R7: reset state
    repeat (2) @(negedge clk);
    check(!tx_drv_hi && !tx_drv_lo, "R7 tx tri-state in reset", int'({tx_drv_hi, tx_drv_lo}), 0);
    check(!rx_drv_hi && !rx_drv_lo, "R7 rx tri-state in reset", int'({rx_drv_hi, rx_drv_lo}), 0);
    check(lock_n == 1'b1, "R7 lock_n high in reset", int'(lock_n), 1);

    // R1 R3 R4: every select, random reference ratio
    for (int s = 0; s < 4; s++) begin
      r = 16 + int'($urandom % 24);
      ref_ratio = 12'(r); rate_sel = 2'(s);
      do_reset(0);
      wait_tick(0); gap_of(0, g);
      check(g == r * mult_of(2'(s), 1'b1), "R4 tx rate", g, r * mult_of(2'(s), 1'b1));
      wait_tick(1); gap_of(1, g);
      check(g == r * mult_of(2'(s), 1'b0), "R3 rx rate", g, r * mult_of(2'(s), 1'b0));
    end

    // R1: clamp of a small reference ratio
    ref_ratio = 12'd5; rate_sel = 2'b00; do_reset(0);
    wait_tick(0); gap_of(0, g);
    check(g == floor16(5), "R1 ref clamp", g, 16);

    // R2: channel dividers, continuous and alternate-cycle enables
    for (int k = 0; k < 3; k++) begin
      r = 10 + int'($urandom % 40);
      rx_ratio = 14'(r); tx_ratio = 14'(r + 3); rx_gate = 1'b0;
      do_reset(0);
      wait_tick(3); gap_of(3, g);
      check(g == floor16(r), "R2 rx divider", g, floor16(r));
      wait_tick(2); gap_of(2, g);
      check(g == floor16(r + 3), "R2 tx divider", g, floor16(r + 3));
      rx_gate = 1'b1;
      wait_tick(3); wait_tick(3); gap_of(3, g);
      check(g == 2 * floor16(r), "R2 rx gated", g, 2 * floor16(r));
      rx_gate = 1'b0;
    end

    // R5: ratio change mid-count
    rx_ratio = 14'd20; do_reset(0);
    wait_tick(3);
    rx_ratio = 14'd33;
    gap_of(3, g); check(g == 20, "R5 old ratio kept", g, 20);
    gap_of(3, g); check(g == 33, "R5 new ratio used", g, 33);

    // R6: polarity, faster tx feedback and slower rx feedback
    ref_ratio = 12'd40; rate_sel = 2'b00; tx_ratio = 14'd30; rx_ratio = 14'd52;
    do_reset(0);
    drive_count(1200, 1'b1, hi, lo);
    check(lo > 0 && hi == 0, "R6 fast tx drives low only", hi, 0);
    do_reset(0);
    drive_count(1200, 1'b0, hi, lo);
    check(hi > 0 && lo == 0, "R6 slow rx drives high only", lo, 0);

    // R7 R8: aligned lock, coincident ticks
    r = 16 + int'($urandom % 24);
    ref_ratio = 12'(r); tx_ratio = 14'(r); rate_sel = 2'b00;
    do_reset(0);
    for (int i = 0; i < 3; i++) wait_tick(0);
    repeat (4) @(negedge clk);
    check(lock_n == 1'b1, "R8 not locked after 3", int'(lock_n), 1);
    wait_tick(0); repeat (4) @(negedge clk);
    check(lock_n == 1'b0, "R8 locked after 4", int'(lock_n), 0);
    drive_count(8 * r, 1'b1, hi, lo);
    check(hi == 0 && lo == 0, "R7 matched tri-state", hi + lo, 0);

    // R9: feedback stops, wide pulse drops lock on next edge
    tx_en_base = 1'b0;
    wait_tick(0); repeat (3) @(negedge clk);
    check(lock_n == 1'b1, "R9 lock dropped", int'(lock_n), 1);
    check(tx_drv_hi == 1'b1, "R9 high drive on lag", int'(tx_drv_hi), 1);
    tx_en_base = 1'b1;

    // R8: one-clock lag still locks on rate B
    tx_ratio = 14'(4 * r); rate_sel = 2'b01;
    do_reset(1);
    for (int i = 0; i < 4; i++) wait_tick(0);
    repeat (4) @(negedge clk);
    check(lock_n == 1'b0, "R8 one-clock pulse tolerated", int'(lock_n), 0);

    // R9: two-clock lag never locks
    do_reset(2);
    for (int i = 0; i < 8; i++) wait_tick(0);
    repeat (4) @(negedge clk);
    check(lock_n == 1'b1, "R9 two-clock pulse rejected", int'(lock_n), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule